// File: doc/BRIEF.md
# Forwarding-table bucket hash unit

This unit maps a station address and its VLAN or filtering identifier onto bucket positions in a 4-way set-associative forwarding table of 16384 entries (4096 buckets). The 48-bit MAC address and the 12-bit VLAN/FID form a 60-bit key. The key is cut into five 11-bit chunks and one 5-bit top chunk. Two 11-bit hashes come from these chunks. The plain hash XORs all chunks together. The alternate hash first rotates two of the chunks and then does the same XOR.

The table has two halves. A per-half select bit picks which hash indexes that half. The lower half uses the hash as its bucket index. The upper half adds 2048 to the hash, so its index lands in buckets 2048..4095. For a requested way, each half also gives an entry address: the bucket index times four, plus the way. The two indices are also packed into one 32-bit word. An optional output register adds one cycle and carries a valid flag with the result.

Top module: `l2_bucket_hash`

## Requirements
- R1: With select 0, a half's 11-bit hash is the XOR of key bits 10:0, 21:11, 32:22, 43:33 and 54:44, plus key bits 59:55 zero-extended to 11 bits.
- R2: With select 1, the chunk at key bits 21:11 is first rotated left by 6 within 11 bits, and the chunk at bits 43:33 is rotated left by 5 within 11 bits. After that, all six chunks are XORed as in R1, and the top chunk is included unchanged.
- R3: The key is the MAC address in bits 59:12 and the VLAN/FID in bits 11:0.
- R4: `alg_sel_i[0]` selects the hash for the lower half and `alg_sel_i[1]` selects it for the upper half. A value of 0 means the plain hash and 1 means the alternate hash.
- R5: The lower-half index `idx0_o` is the selected hash with bit 11 at 0. The upper-half index `idx1_o` is the selected hash plus 2048, so bit 11 is 1.
- R6: Each entry address is the half's 12-bit bucket index shifted left by 2, ORed with `way_i`.
- R7: `packed_o` carries `idx0_o` zero-extended in bits 15:0 and `idx1_o` zero-extended in bits 31:16.
- R8: With the output register present (the default), every result and `valid_o` appear one clock after the inputs are presented with `valid_i` high. During reset, all outputs are 0.
- R9: A cycle with `valid_i` low leaves every result output unchanged and drives `valid_o` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry a request this cycle |
| mac_i | input | 48 | Station MAC address |
| vid_i | input | 12 | VLAN or filtering identifier |
| alg_sel_i | input | 2 | Per-half hash select (bit 0 lower half, bit 1 upper half) |
| way_i | input | 2 | Way within the bucket, used for the entry addresses |
| valid_o | output | 1 | Results below are valid |
| idx0_o | output | 12 | Lower-half bucket index |
| idx1_o | output | 12 | Upper-half bucket index |
| addr0_o | output | 14 | Lower-half entry address |
| addr1_o | output | 14 | Upper-half entry address |
| packed_o | output | 32 | Both indices packed into one word |

## Verification
Every result of a request is due exactly one rising edge after the request was driven. The driver applies inputs on falling edges and records, for each queued expectation, the clock count at which it must appear. The monitor samples on falling edges and compares each output together with the arrival cycle. Hold behaviour is checked two falling edges after the last valid request: by then an idle cycle with a changed key has been clocked in, and `valid_o` must be low while the results still show the earlier request.

// File: rtl/l2h_pkg.sv
package l2h_pkg;
  typedef enum logic {
    HASH_PLAIN = 1'b0,
    HASH_ALT   = 1'b1
  } hash_alg_e;
endpackage

// File: rtl/l2h_fold.sv
module l2h_fold #(
  parameter int KEY_W   = 60,
  parameter int CHUNK_W = 11,
  parameter bit ALT     = 1'b0,
  parameter int ROT_A   = 6,
  parameter int ROT_B   = 5
) (
  input  logic [KEY_W-1:0]   key_i,
  output logic [CHUNK_W-1:0] hash_o
);
  localparam int NFULL = KEY_W / CHUNK_W;
  localparam int TOP_W = KEY_W - NFULL * CHUNK_W;
  localparam int NCH   = (TOP_W > 0) ? NFULL + 1 : NFULL;

  logic [CHUNK_W-1:0] ch [NCH];

  for (genvar i = 0; i < NFULL; i++) begin : g_chunk
    logic [CHUNK_W-1:0] raw;
    assign raw = key_i[i*CHUNK_W +: CHUNK_W];
    if (ALT && i == 1 && ROT_A > 0) begin : g_rot_a
      assign ch[i] = {raw[CHUNK_W-1-ROT_A:0], raw[CHUNK_W-1:CHUNK_W-ROT_A]};
    end else if (ALT && i == 3 && ROT_B > 0) begin : g_rot_b
      assign ch[i] = {raw[CHUNK_W-1-ROT_B:0], raw[CHUNK_W-1:CHUNK_W-ROT_B]};
    end else begin : g_pass
      assign ch[i] = raw;
    end
  end

  if (TOP_W > 0) begin : g_top
    assign ch[NFULL] = {{(CHUNK_W-TOP_W){1'b0}}, key_i[KEY_W-1:NFULL*CHUNK_W]};
  end

  always_comb begin
    hash_o = '0;
    for (int i = 0; i < NCH; i++) hash_o = hash_o ^ ch[i];
  end
endmodule

// File: rtl/l2h_block.sv
module l2h_block #(
  parameter int CHUNK_W = 11,
  parameter int WAY_W   = 2,
  parameter bit UPPER   = 1'b0,
  localparam int IDX_W  = CHUNK_W + 1,
  localparam int ADDR_W = IDX_W + WAY_W
) (
  input  logic               sel_i,
  input  logic [CHUNK_W-1:0] hash_plain_i,
  input  logic [CHUNK_W-1:0] hash_alt_i,
  input  logic [WAY_W-1:0]   way_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ADDR_W-1:0]  addr_o
);
  import l2h_pkg::*;

  logic [CHUNK_W-1:0] hash;
  hash_alg_e          alg;

  assign alg    = hash_alg_e'(sel_i);
  assign hash   = (alg == HASH_ALT) ? hash_alt_i : hash_plain_i;
  // upper half sits one hash space above the lower half
  assign idx_o  = {UPPER, hash};
  assign addr_o = {idx_o, way_i};
endmodule

// File: rtl/l2_bucket_hash.sv
module l2_bucket_hash #(
  parameter int MAC_W   = 48,
  parameter int VID_W   = 12,
  parameter int CHUNK_W = 11,
  parameter int WAY_W   = 2,
  parameter int ROT_A   = 6,
  parameter int ROT_B   = 5,
  parameter int SLOT_W  = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int KEY_W  = MAC_W + VID_W,
  localparam int IDX_W  = CHUNK_W + 1,
  localparam int ADDR_W = IDX_W + WAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [MAC_W-1:0]  mac_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [1:0]        alg_sel_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx0_o,
  output logic [IDX_W-1:0]  idx1_o,
  output logic [ADDR_W-1:0] addr0_o,
  output logic [ADDR_W-1:0] addr1_o,
  output logic [2*SLOT_W-1:0] packed_o
);
  logic [KEY_W-1:0]   key;
  logic [CHUNK_W-1:0] hash [2];
  logic [IDX_W-1:0]   idx  [2];
  logic [ADDR_W-1:0]  addr [2];
  logic [2*SLOT_W-1:0] pack_c;

  assign key = {mac_i, vid_i};

  for (genvar a = 0; a < 2; a++) begin : g_alg
    l2h_fold #(
      .KEY_W(KEY_W), .CHUNK_W(CHUNK_W), .ALT(a == 1), .ROT_A(ROT_A), .ROT_B(ROT_B)
    ) u_fold (
      .key_i(key), .hash_o(hash[a])
    );
  end

  for (genvar b = 0; b < 2; b++) begin : g_blk
    l2h_block #(
      .CHUNK_W(CHUNK_W), .WAY_W(WAY_W), .UPPER(b == 1)
    ) u_blk (
      .sel_i(alg_sel_i[b]), .hash_plain_i(hash[0]), .hash_alt_i(hash[1]),
      .way_i(way_i), .idx_o(idx[b]), .addr_o(addr[b])
    );
  end

  assign pack_c = {{(SLOT_W-IDX_W){1'b0}}, idx[1], {(SLOT_W-IDX_W){1'b0}}, idx[0]};

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o  <= 1'b0;
        idx0_o   <= '0;
        idx1_o   <= '0;
        addr0_o  <= '0;
        addr1_o  <= '0;
        packed_o <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          idx0_o   <= idx[0];
          idx1_o   <= idx[1];
          addr0_o  <= addr[0];
          addr1_o  <= addr[1];
          packed_o <= pack_c;
        end
      end
    end

    assert_valid_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(packed_o) && $stable(addr0_o) && $stable(addr1_o)));
    assert_way_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (addr0_o[WAY_W-1:0] == $past(way_i) && addr1_o[WAY_W-1:0] == $past(way_i)));
    assert_half_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (!idx0_o[IDX_W-1] && idx1_o[IDX_W-1]));
    assert_same_alg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && alg_sel_i[0] == alg_sel_i[1]) |=>
        (idx0_o[CHUNK_W-1:0] == idx1_o[CHUNK_W-1:0]));
    assert_pack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (packed_o[SLOT_W-1:0] == SLOT_W'(addr0_o[ADDR_W-1:WAY_W])
                   && packed_o[2*SLOT_W-1:SLOT_W] == SLOT_W'(addr1_o[ADDR_W-1:WAY_W])));
  end else begin : g_comb
    assign valid_o  = valid_i;
    assign idx0_o   = idx[0];
    assign idx1_o   = idx[1];
    assign addr0_o  = addr[0];
    assign addr1_o  = addr[1];
    assign packed_o = pack_c;
  end
endmodule

// File: tb/tb_l2_bucket_hash.sv
module tb_l2_bucket_hash;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [47:0] mac_i = '0;
  logic [11:0] vid_i = '0;
  logic [1:0]  alg_sel_i = '0;
  logic [1:0]  way_i = '0;
  logic        valid_o;
  logic [11:0] idx0_o, idx1_o;
  logic [13:0] addr0_o, addr1_o;
  logic [31:0] packed_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_bucket_hash dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mac_i(mac_i), .vid_i(vid_i),
    .alg_sel_i(alg_sel_i), .way_i(way_i), .valid_o(valid_o), .idx0_o(idx0_o),
    .idx1_o(idx1_o), .addr0_o(addr0_o), .addr1_o(addr1_o), .packed_o(packed_o)
  );

  typedef struct {
    logic [11:0] idx0, idx1;
    logic [13:0] addr0, addr1;
    logic [31:0] pk;
    int          due;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_e;
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // independent model: key = {mac, vid} (R3)
  function automatic logic [10:0] model_hash(input logic [59:0] k, input bit alt);
    logic [21:0] w1, w3;
    logic [10:0] c1, c3;
    c1 = k[21:11];
    c3 = k[43:33];
    if (alt) begin
      w1 = ({11'b0, c1} << 6) | ({11'b0, c1} >> 5);
      w3 = ({11'b0, c3} << 5) | ({11'b0, c3} >> 6);
      c1 = w1[10:0];
      c3 = w3[10:0];
    end
    return k[10:0] ^ c1 ^ k[32:22] ^ c3 ^ k[54:44] ^ {6'b0, k[59:55]};
  endfunction

  task automatic send(input logic [47:0] m, input logic [11:0] v, input logic [1:0] s, input logic [1:0] w);
    exp_t e;
    logic [59:0] k;
    @(negedge clk);
    mac_i = m; vid_i = v; alg_sel_i = s; way_i = w; valid_i = 1'b1;
    k = {m, v};
    e.idx0  = {1'b0, model_hash(k, s[0])};
    e.idx1  = 12'd2048 + {1'b0, model_hash(k, s[1])};
    e.addr0 = {e.idx0, 2'b00} | {12'b0, w};
    e.addr1 = {e.idx1, 2'b00} | {12'b0, w};
    e.pk    = {4'b0, e.idx1, 4'b0, e.idx0};
    e.due   = cyc + 1;
    exp_q.push_back(e);
    last_e = e;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    mac_i = ~mac_i; vid_i = ~vid_i; way_i = ~way_i; alg_sel_i = ~alg_sel_i;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected valid_o", 32'(valid_o), 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.due, "R8 arrival cycle", 32'(cyc), 32'(e.due));
        chk(idx0_o == e.idx0, "R1/R2/R3/R4 idx0", 32'(idx0_o), 32'(e.idx0));
        chk(idx1_o == e.idx1, "R5 idx1", 32'(idx1_o), 32'(e.idx1));
        chk(addr0_o == e.addr0, "R6 addr0", 32'(addr0_o), 32'(e.addr0));
        chk(addr1_o == e.addr1, "R6 addr1", 32'(addr1_o), 32'(e.addr1));
        chk(packed_o == e.pk, "R7 packed", packed_o, e.pk);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(valid_o == 1'b0, "R8 reset valid_o", 32'(valid_o), 32'd0);
    chk(packed_o == 32'd0, "R8 reset packed_o", packed_o, 32'd0);
    chk(addr1_o == 14'd0, "R8 reset addr1_o", 32'(addr1_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // zero key: idx0 = 0, idx1 = 2048 (R5)
    send(48'h0, 12'h000, 2'b00, 2'd0);
    // top chunk only: hash 0x1F under both algorithms (R1, R2)
    send(48'hF800_0000_0000, 12'h000, 2'b10, 2'd3);
    // key bit 11: plain gives 0x001, alternate gives 0x040 (R2, R3)
    send(48'h0, 12'h800, 2'b10, 2'd1);
    send(48'h0, 12'h800, 2'b01, 2'd2);
    // key bit 33 = mac bit 21: plain 0x001, alternate 0x020 (R2)
    send(48'h0000_0020_0000, 12'h000, 2'b01, 2'd1);
    // all ones key (R1)
    send(48'hFFFF_FFFF_FFFF, 12'hFFF, 2'b00, 2'd3);
    send(48'hFFFF_FFFF_FFFF, 12'hFFF, 2'b11, 2'd0);
    for (int i = 0; i < 200; i++)
      send({$urandom, $urandom}, 12'($urandom), 2'($urandom), 2'($urandom));

    // R9 hold across an idle cycle with changed inputs
    idle();
    @(negedge clk);
    chk(valid_o == 1'b0, "R9 valid_o after idle", 32'(valid_o), 32'd0);
    chk(packed_o == last_e.pk, "R9 packed held", packed_o, last_e.pk);
    chk(addr0_o == last_e.addr0, "R9 addr0 held", 32'(addr0_o), 32'(last_e.addr0));
    chk(idx1_o == last_e.idx1, "R9 idx1 held", 32'(idx1_o), 32'(last_e.idx1));

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing results", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule